// File: doc/BRIEF.md
# Single-Operand Instruction Operand Decoder

This block splits a 16-bit single-operand instruction word into its fields and works out how the operand is to be reached. It reports the operation code, the byte/word selector and the register number. It also gives one of eight operand modes as a one-hot vector. A single two-bit mode field in the word means different things depending on the register it names. Register 0 (the program counter), register 2 (the status register) and register 3 turn that field into symbolic, absolute, immediate or built-in constant modes. The decoder resolves that aliasing so that later stages see only one clean mode.

Alongside the mode, the block reports several derived values. It says whether an extension word has to be fetched after the instruction. It gives the value of a built-in constant and the post-increment step for the autoincrement mode. When the core supplies the extension word, the program counter and the value of the named register, the block forms the effective address for the indexed, symbolic and absolute modes. It also flags when a byte operation in register mode must clear the upper byte of the register. Words outside the single-operand encoding space are marked invalid. All outputs come from one register stage.

Top module: `sop_operand_decoder`

## Requirements
- R1: `valid_o` is 1 exactly when instruction bits [15:10] equal 000100 and the operation code in bits [9:7] is not 7.
- R2: For every word, valid or not, `opcode_o` is bits [9:7], `byte_o` is bit 6 and `reg_num_o` is bits [3:0].
- R3: A valid word uses a built-in constant (mode bit 7) when the register is 3, for any value of the mode field in bits [5:4], or when the register is 2 with a mode field of 2 or 3. Register 2 gives 4 for mode field 2 and 8 for mode field 3. Register 3 gives 0, 1, 2 and all ones for mode fields 0, 1, 2 and 3. `cg_val_o` is 0 in every other mode.
- R4: Mode field 0 on a non-constant register selects register mode (mode bit 0). `clr_hi_o` is 1 exactly when the mode is register mode and bit 6 is 1.
- R5: Mode field 1 selects one of three modes. Register 0 gives symbolic mode (bit 2) with `ea_o` = pc + extension. Register 2 gives absolute mode (bit 3) with `ea_o` = extension. Any other non-constant register gives indexed mode (bit 1) with `ea_o` = register value + extension. Sums wrap modulo 2^DATA_W, and `ea_o` is 0 in all other modes.
- R6: Mode field 2 on a non-constant register selects register-indirect mode (mode bit 4).
- R7: Mode field 3 with register 0 selects immediate mode (mode bit 6). With any other non-constant register it selects indirect-autoincrement mode (mode bit 5), and `step_o` is 2 for word operations (bit 6 = 0) and 1 for byte operations. `step_o` is 0 in every other mode.
- R8: `need_ext_o` is 1 exactly in the indexed, symbolic, absolute and immediate modes, so never while a built-in constant is used.
- R9: While `valid_o` is 1, exactly one bit of `mode_o` is set.
- R10: While `valid_o` is 0, `mode_o`, `need_ext_o`, `cg_val_o`, `step_o`, `clr_hi_o` and `ea_o` are all 0.
- R11: Every output shows the inputs captured at the previous rising edge of `clk`. While `rst_n` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word |
| ext_word_i | input | DATA_W | Extension word that follows the instruction |
| pc_i | input | DATA_W | Program counter value used for symbolic mode |
| reg_val_i | input | DATA_W | Value of the register named by bits [3:0] |
| valid_o | output | 1 | Word is a legal single-operand instruction |
| opcode_o | output | 3 | Operation code |
| byte_o | output | 1 | Byte (1) or word (0) operation |
| reg_num_o | output | 4 | Register number |
| mode_o | output | 8 | One-hot mode: 0 reg, 1 indexed, 2 symbolic, 3 absolute, 4 indirect, 5 autoincrement, 6 immediate, 7 constant |
| need_ext_o | output | 1 | An extension word must be fetched |
| cg_val_o | output | DATA_W | Built-in constant value |
| step_o | output | 2 | Autoincrement step |
| clr_hi_o | output | 1 | Clear the upper byte of the register |
| ea_o | output | DATA_W | Effective address |

## Verification
The bench sweeps all 65536 instruction words, so every combination of prefix, operation code, selector, mode field and register is tried. This separates the register aliases (0, 2, 3) from ordinary registers, and legal words from rejected ones. The extension, pc and register values change with each word, so a mix-up between symbolic, absolute and indexed addressing shows up as a wrong `ea_o`. Directed words check wrap-around of the address sums, the one-cycle latency and the reset state.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int INSTR_W = 16;
  localparam int MODE_N  = 8;

  // one-hot mode bit positions
  localparam int M_REG  = 0;
  localparam int M_IDX  = 1;
  localparam int M_SYM  = 2;
  localparam int M_ABS  = 3;
  localparam int M_IND  = 4;
  localparam int M_AINC = 5;
  localparam int M_IMM  = 6;
  localparam int M_CON  = 7;

  localparam logic [5:0] PREFIX   = 6'b000100;
  localparam logic [2:0] OPC_BAD  = 3'd7;
  localparam logic [3:0] R_PC     = 4'd0;
  localparam logic [3:0] R_SR     = 4'd2;
  localparam logic [3:0] R_CG     = 4'd3;

  typedef struct packed {
    logic [5:0] top;
    logic [2:0] opc;
    logic       bw;
    logic [1:0] am;
    logic [3:0] rn;
  } sop_word_t;

  function automatic logic cg_hit(input logic [3:0] rn, input logic [1:0] am);
    return (rn == R_CG) || ((rn == R_SR) && am[1]);
  endfunction

  function automatic logic [3:0] cg_small(input logic [3:0] rn, input logic [1:0] am);
    logic [3:0] v;
    if (rn == R_SR) v = am[0] ? 4'd8 : 4'd4;
    else begin
      case (am)
        2'd1:    v = 4'd1;
        2'd2:    v = 4'd2;
        default: v = 4'd0;
      endcase
    end
    return v;
  endfunction

  function automatic logic cg_all_ones(input logic [3:0] rn, input logic [1:0] am);
    return (rn == R_CG) && (am == 2'd3);
  endfunction

  function automatic logic [1:0] ainc_step(input logic bw);
    return bw ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/sop_field_split.sv
module sop_field_split
  import sop_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output sop_word_t          fld_o,
  output logic               word_ok_o
);
  assign fld_o     = sop_word_t'(instr_i);
  assign word_ok_o = (fld_o.top == PREFIX) && (fld_o.opc != OPC_BAD);
endmodule

// File: rtl/sop_mode_sel.sv
module sop_mode_sel
  import sop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              word_ok_i,
  input  logic              bw_i,
  input  logic [1:0]        am_i,
  input  logic [3:0]        rn_i,
  output logic [MODE_N-1:0] mode_o,
  output logic              need_ext_o,
  output logic [DATA_W-1:0] cg_val_o,
  output logic [1:0]        step_o,
  output logic              clr_hi_o,
  output logic              cg_active_o
);
  localparam int PAD_W = DATA_W - 4;

  assign cg_active_o = word_ok_i && cg_hit(rn_i, am_i);

  always_comb begin
    mode_o     = '0;
    need_ext_o = 1'b0;
    cg_val_o   = '0;
    step_o     = 2'd0;
    clr_hi_o   = 1'b0;
    if (word_ok_i) begin
      if (cg_active_o) begin
        mode_o[M_CON] = 1'b1;
        cg_val_o = cg_all_ones(rn_i, am_i) ? '1
                                            : {{PAD_W{1'b0}}, cg_small(rn_i, am_i)};
      end else begin
        case (am_i)
          2'd0: begin
            mode_o[M_REG] = 1'b1;
            clr_hi_o      = bw_i;
          end
          2'd1: begin
            need_ext_o = 1'b1;
            if (rn_i == R_PC)      mode_o[M_SYM] = 1'b1;
            else if (rn_i == R_SR) mode_o[M_ABS] = 1'b1;
            else                   mode_o[M_IDX] = 1'b1;
          end
          2'd2: mode_o[M_IND] = 1'b1;
          default: begin
            if (rn_i == R_PC) begin
              mode_o[M_IMM] = 1'b1;
              need_ext_o    = 1'b1;
            end else begin
              mode_o[M_AINC] = 1'b1;
              step_o         = ainc_step(bw_i);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sop_addr_gen.sv
module sop_addr_gen #(
  parameter int DATA_W = 16
) (
  input  logic              sym_i,
  input  logic              abs_i,
  input  logic              idx_i,
  input  logic [DATA_W-1:0] ext_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] rv_i,
  output logic [DATA_W-1:0] ea_o
);
  always_comb begin
    if (sym_i)      ea_o = pc_i + ext_i;
    else if (abs_i) ea_o = ext_i;
    else if (idx_i) ea_o = rv_i + ext_i;
    else            ea_o = '0;
  end
endmodule

// File: rtl/sop_operand_decoder.sv
module sop_operand_decoder
  import sop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       instr_i,
  input  logic [DATA_W-1:0] ext_word_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] reg_val_i,
  output logic              valid_o,
  output logic [2:0]        opcode_o,
  output logic              byte_o,
  output logic [3:0]        reg_num_o,
  output logic [7:0]        mode_o,
  output logic              need_ext_o,
  output logic [DATA_W-1:0] cg_val_o,
  output logic [1:0]        step_o,
  output logic              clr_hi_o,
  output logic [DATA_W-1:0] ea_o
);
  sop_word_t         fld_w;
  logic              word_ok_w;
  logic [MODE_N-1:0] mode_w;
  logic              need_ext_w;
  logic [DATA_W-1:0] cg_val_w;
  logic [1:0]        step_w;
  logic              clr_hi_w;
  logic              cg_active_w;
  logic [DATA_W-1:0] ea_w;

  sop_field_split u_split (
    .instr_i   (instr_i),
    .fld_o     (fld_w),
    .word_ok_o (word_ok_w)
  );

  sop_mode_sel #(.DATA_W(DATA_W)) u_mode (
    .word_ok_i   (word_ok_w),
    .bw_i        (fld_w.bw),
    .am_i        (fld_w.am),
    .rn_i        (fld_w.rn),
    .mode_o      (mode_w),
    .need_ext_o  (need_ext_w),
    .cg_val_o    (cg_val_w),
    .step_o      (step_w),
    .clr_hi_o    (clr_hi_w),
    .cg_active_o (cg_active_w)
  );

  sop_addr_gen #(.DATA_W(DATA_W)) u_addr (
    .sym_i (mode_w[M_SYM]),
    .abs_i (mode_w[M_ABS]),
    .idx_i (mode_w[M_IDX]),
    .ext_i (ext_word_i),
    .pc_i  (pc_i),
    .rv_i  (reg_val_i),
    .ea_o  (ea_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o    <= 1'b0;
      opcode_o   <= '0;
      byte_o     <= 1'b0;
      reg_num_o  <= '0;
      mode_o     <= '0;
      need_ext_o <= 1'b0;
      cg_val_o   <= '0;
      step_o     <= '0;
      clr_hi_o   <= 1'b0;
      ea_o       <= '0;
    end else begin
      valid_o    <= word_ok_w;
      opcode_o   <= fld_w.opc;
      byte_o     <= fld_w.bw;
      reg_num_o  <= fld_w.rn;
      mode_o     <= mode_w;
      need_ext_o <= need_ext_w;
      cg_val_o   <= cg_val_w;
      step_o     <= step_w;
      clr_hi_o   <= clr_hi_w;
      ea_o       <= ea_w;
    end
  end
endmodule

// File: rtl/sop_decoder_chk.sv
module sop_decoder_chk
  import sop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ext_word_i,
  input logic              valid_o,
  input logic              byte_o,
  input logic [3:0]        reg_num_o,
  input logic [7:0]        mode_o,
  input logic              need_ext_o,
  input logic [DATA_W-1:0] cg_val_o,
  input logic [1:0]        step_o,
  input logic              clr_hi_o,
  input logic [DATA_W-1:0] ea_o,
  input logic              cg_active_w
);
  // R9
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($countones(mode_o) == 1));

  // R10
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (mode_o == '0 && !need_ext_o && cg_val_o == '0 &&
                  step_o == 2'd0 && !clr_hi_o && ea_o == '0));

  // R8
  ext_vs_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[M_CON] |-> !need_ext_o);

  // R3
  const_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cg_active_w |=> mode_o[M_CON]);

  // R3
  reg3_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && reg_num_o == R_CG) |-> mode_o[M_CON]);

  // R5
  abs_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[M_ABS] |-> (ea_o == $past(ext_word_i)));

  // R7
  step_ainc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o != 2'd0) |-> (mode_o[M_AINC] && (step_o == (byte_o ? 2'd1 : 2'd2))));

  // R4
  clr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hi_o |-> (mode_o[M_REG] && byte_o));
endmodule

bind sop_operand_decoder sop_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_word_i  (ext_word_i),
  .valid_o     (valid_o),
  .byte_o      (byte_o),
  .reg_num_o   (reg_num_o),
  .mode_o      (mode_o),
  .need_ext_o  (need_ext_o),
  .cg_val_o    (cg_val_o),
  .step_o      (step_o),
  .clr_hi_o    (clr_hi_o),
  .ea_o        (ea_o),
  .cg_active_w (cg_active_w)
);

// File: tb/tb_sop_operand_decoder.sv
`timescale 1ns/1ps
module tb_sop_operand_decoder;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   instr = 16'h1000;
  logic [DW-1:0] ext = '0, pc = '0, rv = '0;
  logic          valid_o, byte_o, need_ext_o, clr_hi_o;
  logic [2:0]    opcode_o;
  logic [3:0]    reg_num_o;
  logic [7:0]    mode_o;
  logic [DW-1:0] cg_val_o, ea_o;
  logic [1:0]    step_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sop_operand_decoder #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .ext_word_i(ext), .pc_i(pc),
    .reg_val_i(rv), .valid_o(valid_o), .opcode_o(opcode_o), .byte_o(byte_o),
    .reg_num_o(reg_num_o), .mode_o(mode_o), .need_ext_o(need_ext_o),
    .cg_val_o(cg_val_o), .step_o(step_o), .clr_hi_o(clr_hi_o), .ea_o(ea_o)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // expected-value model written from the requirements
  task automatic model(input logic [15:0] w, input logic [DW-1:0] e, p, r,
                       output logic v, output logic [7:0] m, output logic ne,
                       output logic [DW-1:0] cg, output logic [1:0] st,
                       output logic clr, output logic [DW-1:0] ea, output string rq);
    logic [1:0] a;
    logic [3:0] n;
    a = w[5:4];
    n = w[3:0];
    v = (w[15:10] == 6'b000100) && (w[9:7] != 3'd7);
    m = 8'h00; ne = 1'b0; cg = '0; st = 2'd0; clr = 1'b0; ea = '0; rq = "R10";
    if (v) begin
      if (n == 4'd3) begin
        m = 8'h80; rq = "R3";
        cg = (a == 2'd3) ? 16'hFFFF : {14'd0, a};
      end else if (n == 4'd2 && a >= 2'd2) begin
        m = 8'h80; rq = "R3";
        cg = (a == 2'd2) ? 16'd4 : 16'd8;
      end else if (a == 2'd0) begin
        m = 8'h01; rq = "R4"; clr = w[6];
      end else if (a == 2'd1) begin
        ne = 1'b1; rq = "R5";
        if (n == 4'd0)      begin m = 8'h04; ea = p + e; end
        else if (n == 4'd2) begin m = 8'h08; ea = e; end
        else                begin m = 8'h02; ea = r + e; end
      end else if (a == 2'd2) begin
        m = 8'h10; rq = "R6";
      end else if (n == 4'd0) begin
        m = 8'h40; ne = 1'b1; rq = "R7";
      end else begin
        m = 8'h20; rq = "R7"; st = w[6] ? 2'd1 : 2'd2;
      end
    end
  endtask

  task automatic run_word(input logic [15:0] w, input logic [DW-1:0] e, p, r);
    logic v, ne, clr;
    logic [7:0] m;
    logic [DW-1:0] cg, ea;
    logic [1:0] st;
    string rq;
    @(negedge clk);
    instr = w; ext = e; pc = p; rv = r;
    @(posedge clk);
    #1;
    model(w, e, p, r, v, m, ne, cg, st, clr, ea, rq);
    chk("R1", "valid", 32'(valid_o), 32'(v));
    chk("R2", "fields", {25'd0, opcode_o, byte_o, reg_num_o}, {25'd0, w[9:6], w[3:0]});
    chk(rq, "mode", 32'(mode_o), 32'(m));
    chk("R8", "need_ext", 32'(need_ext_o), 32'(ne));
    chk("R3", "cg_val", 32'(cg_val_o), 32'(cg));
    chk("R7", "step", 32'(step_o), 32'(st));
    chk("R4", "clr_hi", 32'(clr_hi_o), 32'(clr));
    chk("R5", "ea", 32'(ea_o), 32'(ea));
    if (valid_o) chk("R9", "mode bits set", 32'($countones(mode_o)), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state, R11
    instr = 16'h1234; ext = 16'h5555;
    repeat (3) @(negedge clk);
    chk("R11", "reset valid", 32'(valid_o), 32'd0);
    chk("R11", "reset mode", 32'(mode_o), 32'd0);
    chk("R11", "reset fields", {25'd0, opcode_o, byte_o, reg_num_o}, 32'd0);
    chk("R11", "reset ea/cg", {ea_o, cg_val_o}, 32'd0);
    rst_n = 1'b1;

    // R11 one-cycle latency: output holds until the next rising edge
    run_word(16'h1085, 16'h0010, 16'h0000, 16'h0100);
    @(negedge clk);
    instr = 16'h10A9;
    #1;
    chk("R11", "hold before edge", 32'(reg_num_o), 32'd5);
    @(posedge clk);
    #1;
    chk("R11", "after edge", 32'(reg_num_o), 32'd9);

    // R5 wrap-around of address sums
    run_word(16'h1014, 16'h0002, 16'h0000, 16'hFFFF); // indexed r4
    chk("R5", "indexed wrap", 32'(ea_o), 32'h0001);
    run_word(16'h1010, 16'hFFFE, 16'h0004, 16'h0000); // symbolic
    chk("R5", "symbolic wrap", 32'(ea_o), 32'h0002);
    run_word(16'h1012, 16'hC0DE, 16'h1111, 16'h2222); // absolute
    chk("R5", "absolute ea", 32'(ea_o), 32'hC0DE);

    // R7 byte vs word step on the same register
    run_word(16'h1075, 16'h0, 16'h0, 16'h0);
    chk("R7", "byte step", 32'(step_o), 32'd1);
    run_word(16'h1035, 16'h0, 16'h0, 16'h0);
    chk("R7", "word step", 32'(step_o), 32'd2);

    // R1 opcode 7 rejected, R10 quiet
    run_word(16'h13B5, 16'h1, 16'h2, 16'h3);
    chk("R1", "opcode 7", 32'(valid_o), 32'd0);
    chk("R10", "opcode 7 quiet", 32'(step_o), 32'd0);

    // exhaustive sweep of all instruction words
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] e, p, r;
      e = 16'(i * 16'h9E37) + 16'h00A5;
      p = ~16'(i) ^ 16'h3C00;
      r = {8'(i), 8'(i >> 8)} + 16'h0101;
      run_word(16'(i), e, p, r);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule